// File: doc/BRIEF.md
# Dual Bridge-Sensor ADC Serial Reader

This block reads two 24-bit bridge-sensor converters that share one serial clock output and have separate data inputs. It waits until both converters report a finished conversion by pulling their data lines low. It then sends one timed clock pulse per bit and captures one bit from each line at the end of every pulse, most significant bit first. After the 24 data pulses it sends a 25th pulse with no capture. That pulse sets up the converters for channel A at gain 128 on the next conversion.

Both 24-bit words are two's complement. Each is sign-extended to the output width and presented as a pair, together with a one-cycle valid strobe. The pulse timing comes from an internal divider of the system clock. Both data inputs pass through two-flop synchronisers before the block uses them.

The controller is a state machine with five states:
- `ST_IDLE`: waits for both ready lines to be low.
- `ST_LAUNCH`: fires a data pulse.
- `ST_SHIFT`: waits for the data pulse to end, then captures a bit.
- `ST_TRAIL`: fires the extra pulse.
- `ST_TRAIL_WAIT`: waits for the extra pulse to end.

The transitions are:
- **ready**: `ST_IDLE`→`ST_LAUNCH`, taken when both synchronised inputs are low. This also clears the accumulators.
- **fire**: `ST_LAUNCH`→`ST_SHIFT`.
- **next bit**: `ST_SHIFT`→`ST_LAUNCH`, taken when a pulse ends and bits remain.
- **last bit**: `ST_SHIFT`→`ST_TRAIL`, taken when the 24th pulse ends.
- **fire extra**: `ST_TRAIL`→`ST_TRAIL_WAIT`.
- **publish**: `ST_TRAIL_WAIT`→`ST_IDLE`, taken when the extra pulse ends. This loads the results and raises valid.

Top module: `dual_bridge_adc_reader`

## Requirements
- R1: A synchronous active-high reset puts the block in the idle state. After reset `sclk` is low, `sample_valid` is low, and both results read 0.
- R2: A read starts only when both synchronised data inputs are low. While only one of them is low, no pulse appears on `sclk`.
- R3: Every read produces exactly 25 high pulses on `sclk`: 24 data pulses and then one extra pulse.
- R4: On each data pulse, one bit is taken from each data input. The sample is taken after the pulse period has fully elapsed, that is after the high phase and the low phase. The first bit taken is the most significant bit of the word, and each new bit enters at the least significant end.
- R5: Each 24-bit word is sign-extended to `OUT_W` bits. For example, 0x7FFFFF gives 8388607, 0x800000 gives -8388608, and 0xFFFFFF gives -1.
- R6: Each pulse is high for ceil(`PULSE_CYC`/2) system clock cycles. It is then low for at least the remaining `PULSE_CYC` - ceil(`PULSE_CYC`/2) cycles before the next pulse rises.
- R7: `sample_valid` is high for exactly one cycle after the extra pulse ends. The block then returns to waiting for ready.
- R8: The two channels are captured on the same pulses, and each channel's word is independent of the other's.
- R9: `sclk` stays low whenever the block is idle.
- R10: The level on the data inputs during the extra pulse has no effect on either result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dout_a | input | 1 | Serial data / ready line of converter A (low = ready) |
| dout_b | input | 1 | Serial data / ready line of converter B (low = ready) |
| sclk | output | 1 | Shared serial clock; high is the active pulse |
| sample_valid | output | 1 | One-cycle strobe: both results are new |
| result_a | output | OUT_W | Sign-extended word from converter A |
| result_b | output | OUT_W | Sign-extended word from converter B |

## Verification
The assertions check the following on every cycle:
- The clock stays low while the block is idle.
- A read is entered only after both ready lines were seen low.
- The bit counter stays in range.
- The pulse generator is never fired while it is busy.
- The valid strobe lasts one cycle and directly follows the end of the extra pulse.

Other behaviours can only be shown by the bench's scenarios, which use a converter model that shifts a bit out on each rising clock. These are:
- The bit order and the pairing of the two words.
- The exact count of 25 pulses.
- The high and low widths of each pulse.
- The sign-extension values.
- That staggered ready lines hold off the read.
- That the level on the data lines during the extra pulse does not matter.

// File: rtl/bridge_rd_pkg.sv
package bridge_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_SHIFT,
        ST_TRAIL,
        ST_TRAIL_WAIT
    } rd_state_t;
endpackage

// File: rtl/bit_sync2.sv
module bit_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Reset to all ones: a converter is treated as not ready.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/sclk_oneshot.sv
module sclk_oneshot #(
    parameter int PULSE_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic sclk,
    output logic done
);
    localparam int HIGH_CYC = (PULSE_CYC + 1) / 2;
    localparam int CNT_W    = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HI_LIM   = CNT_W'(HIGH_CYC);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (fire && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST_CNT) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign sclk = busy && (cnt < HI_LIM);
    assign done = busy && (cnt == LAST_CNT);

    // R6
    no_refire_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> !busy);
    // R6
    done_ends_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !sclk);
endmodule

// File: rtl/dual_bridge_adc_reader.sv
module dual_bridge_adc_reader
    import bridge_rd_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int OUT_W     = 32,
    parameter int PULSE_CYC = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dout_a,
    input  logic             dout_b,
    output logic             sclk,
    output logic             sample_valid,
    output logic [OUT_W-1:0] result_a,
    output logic [OUT_W-1:0] result_b
);
    localparam int BC_W = $clog2(DATA_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);
    localparam int EXT_W = OUT_W - DATA_W;

    rd_state_t         state, state_nx;
    logic [1:0]        din_s;
    logic              rdy_both;
    logic              fire;
    logic              pulse_done;
    logic [BC_W-1:0]   bit_cnt;
    logic [DATA_W-1:0] acc_a, acc_b;

    bit_sync2 #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dout_b, dout_a}),
        .q   (din_s)
    );

    sclk_oneshot #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .sclk (sclk),
        .done (pulse_done)
    );

    assign rdy_both = (din_s == 2'b00);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (rdy_both) state_nx = ST_LAUNCH;
            ST_LAUNCH:     state_nx = ST_SHIFT;
            ST_SHIFT:      if (pulse_done)
                               state_nx = (bit_cnt == LAST_BIT) ? ST_TRAIL : ST_LAUNCH;
            ST_TRAIL:      state_nx = ST_TRAIL_WAIT;
            ST_TRAIL_WAIT: if (pulse_done) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // Outputs from state
    always_comb begin
        fire = 1'b0;
        unique case (state)
            ST_LAUNCH, ST_TRAIL: fire = 1'b1;
            default:             fire = 1'b0;
        endcase
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt      <= '0;
            acc_a        <= '0;
            acc_b        <= '0;
            result_a     <= '0;
            result_b     <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            if (state == ST_IDLE && rdy_both) begin
                bit_cnt <= '0;
                acc_a   <= '0;
                acc_b   <= '0;
            end
            if (state == ST_SHIFT && pulse_done) begin
                acc_a   <= {acc_a[DATA_W-2:0], din_s[0]};
                acc_b   <= {acc_b[DATA_W-2:0], din_s[1]};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == ST_TRAIL_WAIT && pulse_done) begin
                result_a     <= {{EXT_W{acc_a[DATA_W-1]}}, acc_a};
                result_b     <= {{EXT_W{acc_b[DATA_W-1]}}, acc_b};
                sample_valid <= 1'b1;
            end
        end
    end

    // R9
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sclk);
    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);
    // R7
    valid_after_tail_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> ($past(state) == ST_TRAIL_WAIT));
    // R3
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT) |-> (bit_cnt <= LAST_BIT));
    // R2
    start_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_IDLE && state == ST_LAUNCH) |-> ($past(din_s) == 2'b00));
endmodule

// File: tb/tb_dual_bridge_adc_reader.sv
module tb_dual_bridge_adc_reader;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 24;
    localparam int OUT_W      = 32;
    localparam int PULSE_CYC  = 5;
    localparam int HIGH_CYC   = (PULSE_CYC + 1) / 2;
    localparam int LOW_CYC    = PULSE_CYC - HIGH_CYC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dout_a = 1'b1, dout_b = 1'b1;
    logic sclk, sample_valid;
    logic [OUT_W-1:0] result_a, result_b;

    int tests = 0, fails = 0;
    int edge_idx = 0;
    int hi_run = 0, lo_run = 0, hi_bad = 0, lo_bad = 0;
    logic [DATA_W-1:0] wa = '0, wb = '0;
    logic junk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bridge_adc_reader #(.DATA_W(DATA_W), .OUT_W(OUT_W), .PULSE_CYC(PULSE_CYC)) dut (
        .clk(clk), .rst(rst), .dout_a(dout_a), .dout_b(dout_b),
        .sclk(sclk), .sample_valid(sample_valid),
        .result_a(result_a), .result_b(result_b)
    );

    function automatic logic [OUT_W-1:0] sext(input logic [DATA_W-1:0] w);
        return {{(OUT_W-DATA_W){w[DATA_W-1]}}, w};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model: a new bit appears shortly after each rising clock.
    always @(posedge sclk) begin
        edge_idx = edge_idx + 1;
        #1;
        if (edge_idx <= DATA_W) begin
            dout_a = wa[DATA_W - edge_idx];
            dout_b = wb[DATA_W - edge_idx];
        end else begin
            dout_a = junk;          // R10: arbitrary level during extra pulse
            dout_b = ~junk;
        end
    end
    always @(negedge sclk) begin
        if (edge_idx > DATA_W) begin
            #1;
            dout_a = 1'b1;
            dout_b = 1'b1;
        end
    end

    // Pulse width monitor
    always @(negedge clk) begin
        if (sclk) begin
            if (lo_run > 0 && edge_idx > 1 && lo_run < LOW_CYC) lo_bad++;
            lo_run = 0;
            hi_run++;
        end else begin
            if (hi_run > 0 && hi_run != HIGH_CYC) hi_bad++;
            hi_run = 0;
            lo_run++;
        end
    end

    task automatic do_read(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                           input int gap_a, input int gap_b, input string tag);
        int waited;
        wa = a; wb = b; junk = 1'($urandom);
        edge_idx = 0; hi_bad = 0; lo_bad = 0;
        repeat (gap_a) @(negedge clk);
        dout_a = 1'b0;
        repeat (gap_b) @(negedge clk);
        // R2: with only A ready no pulse yet
        chk({tag, " R2 no pulse before both ready"}, 64'(edge_idx), 64'd0);
        dout_b = 1'b0;
        waited = 0;
        while (!sample_valid && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " R7 valid seen"}, 64'(sample_valid), 64'd1);
        chk({tag, " R3 pulse count"}, 64'(edge_idx), 64'(DATA_W + 1));
        chk({tag, " R4 R5 R10 result A"}, 64'(result_a), 64'(sext(a)));
        chk({tag, " R8 result B"}, 64'(result_b), 64'(sext(b)));
        chk({tag, " R6 high width"}, 64'(hi_bad), 64'd0);
        chk({tag, " R6 low width"}, 64'(lo_bad), 64'd0);
        @(negedge clk);
        chk({tag, " R7 valid one cycle"}, 64'(sample_valid), 64'd0);
        chk({tag, " R9 sclk idle low"}, 64'(sclk), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sclk", 64'(sclk), 64'd0);
        chk("R1 valid", 64'(sample_valid), 64'd0);
        chk("R1 result_a", 64'(result_a), 64'd0);
        chk("R1 result_b", 64'(result_b), 64'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R5 directed corner words
        do_read(24'h000000, 24'hFFFFFF, 4, 30, "zero/neg1");
        do_read(24'h7FFFFF, 24'h800000, 10, 5, "maxpos/maxneg");
        do_read(24'h800000, 24'h7FFFFF, 2, 2, "swap");
        do_read(24'hA5A5A5, 24'h5A5A5A, 3, 60, "alt");
        do_read(24'h000001, 24'h800001, 1, 1, "lsb");

        // Constrained random words, random stagger of ready lines
        for (int i = 0; i < 20; i++) begin
            do_read(DATA_W'($urandom), DATA_W'($urandom),
                    1 + int'($urandom % 8), 1 + int'($urandom % 40), "rand");
        end

        // R2: B ready alone for a long time gives no pulse
        edge_idx = 0;
        dout_b = 1'b0;
        repeat (50) @(negedge clk);
        chk("R2 only B ready", 64'(edge_idx), 64'd0);
        dout_b = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule